// File: doc/BRIEF.md
# Programmable Decision-Diagram Path Evaluator

This block computes a single Boolean output from an input vector. It does so by walking a structurally synthesised binary decision diagram that a host has loaded into a small on-chip node table. Each table entry names one input bit and may complement it. The entry also holds two successor pointers: one taken when the literal is 1 ("right") and one taken when it is 0 ("down"). A successor may be absent. An absent successor ends the walk at the constant terminal implied by the edge direction, so the table never stores terminal nodes.

A one-cycle start pulse latches the input vector, and the walk begins at the root entry. The block then advances one node per clock. When the walk reaches a terminal, it raises a one-cycle done pulse and presents the result and the number of nodes it visited. A visit guard stops any walk that would exceed the table depth and flags an error, which protects against a table loaded with a cycle. Several entries may test the same input bit, which is how fanout branches of one input are represented.

Top module: `ssbdd_eval`

## Requirements
- R1: After synchronous reset, busy, done, result, error and visits are 0. Every table entry reads as: variable 0, not complemented, both successors absent. A walk on the reset table therefore visits 1 node and returns input bit 0.
- R2: A start pulse while idle latches in_vec and begins at table address 0. Busy is 1 in the following cycle, with visits and error cleared. Done rises exactly N cycles after the start edge, where N is the number of nodes visited.
- R3: At each node the literal is in_vec[var] XOR complement. A literal of 1 follows the right successor, and a literal of 0 follows the down successor.
- R4: Any successor code of 16 or above, with 31 as the canonical value, means the edge is absent. Following an absent right edge gives result 1, and following an absent down edge gives result 0. In both cases visits equals the number of nodes evaluated.
- R5: Done is high for exactly one cycle. Result, error and visits then hold until the next accepted start.
- R6: Table writes presented while busy are discarded, and the walk and all later walks use the unchanged entry.
- R7: A start pulse while busy is ignored. The running walk completes on its originally latched vector.
- R8: If 16 nodes have been visited and the 16th node still has a present successor, the walk ends with done. At that point error is 1, result is 0 and visits is 16.
- R9: With a=bit0, b=bit1, c=bit2 and d=bit3, a five-entry table implements y = a·b·c + ¬c·¬d. Input 1,1,1,0 gives 1 after 3 visits, and input 1,0,0,1 gives 0 after 4 visits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe (honoured only while idle) |
| wr_addr | input | 4 | Entry address to write |
| wr_var | input | 3 | Input-bit index tested by the entry |
| wr_cmpl | input | 1 | Entry tests the complement of its input bit |
| wr_right | input | 5 | Successor when literal is 1; 16 or above means absent |
| wr_down | input | 5 | Successor when literal is 0; 16 or above means absent |
| start | input | 1 | Begin a walk and latch in_vec |
| in_vec | input | 8 | Input vector |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Terminal constant reached |
| error | output | 1 | Walk stopped by the visit guard |
| visits | output | 5 | Nodes visited by the last walk |

## Verification
The bench uses the package defaults: 16 table entries and an 8-bit input vector. With these values a 16-node chain table reaches the full visit limit, and the same chain closed into a loop trips the guard within a few dozen cycles. That chain also keeps a walk busy long enough to inject a write and a second start in its middle. Random forward-only tables with random absent edges exercise both edge directions and the complement flag on every input bit. The example function is then swept over all sixteen values of a, b, c and d.

// File: rtl/ssbdd_pkg.sv
package ssbdd_pkg;

    localparam int SB_NODES  = 16;
    localparam int SB_NVARS  = 8;
    localparam int SB_ADDR_W = $clog2(SB_NODES);
    localparam int SB_VIDX_W = $clog2(SB_NVARS);
    localparam int SB_PTR_W  = SB_ADDR_W + 1;
    localparam int SB_CNT_W  = $clog2(SB_NODES + 1);

    typedef logic [SB_PTR_W-1:0]  ptr_t;
    typedef logic [SB_ADDR_W-1:0] addr_t;
    typedef logic [SB_NVARS-1:0]  vec_t;
    typedef logic [SB_CNT_W-1:0]  cnt_t;

    localparam ptr_t SB_NO_EDGE = {SB_PTR_W{1'b1}};

    typedef struct packed {
        logic [SB_VIDX_W-1:0] var_idx;
        logic                 cmpl;
        ptr_t                 right;
        ptr_t                 down;
    } node_t;

    typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;

    function automatic logic edge_present(ptr_t p);
        return p < SB_PTR_W'(SB_NODES);
    endfunction

    function automatic node_t blank_node();
        node_t n;
        n.var_idx = '0;
        n.cmpl    = 1'b0;
        n.right   = SB_NO_EDGE;
        n.down    = SB_NO_EDGE;
        return n;
    endfunction

endpackage

// File: rtl/ssbdd_node_table.sv
module ssbdd_node_table
    import ssbdd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  node_t wdata,
    input  addr_t raddr,
    output node_t rdata
);
    node_t mem [SB_NODES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SB_NODES; i++) mem[i] <= blank_node();
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ssbdd_lit_sel.sv
module ssbdd_lit_sel
    import ssbdd_pkg::*;
(
    input  vec_t  vec,
    input  node_t node,
    output logic  lit,
    output ptr_t  nxt,
    output logic  has_next
);
    always_comb begin
        lit      = vec[node.var_idx] ^ node.cmpl;
        nxt      = lit ? node.right : node.down;
        has_next = edge_present(nxt);
    end
endmodule

// File: rtl/ssbdd_walker.sv
module ssbdd_walker
    import ssbdd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  vec_t  in_vec,
    input  logic  lit,
    input  ptr_t  nxt,
    input  logic  has_next,
    output vec_t  vec_q,
    output addr_t cur,
    output logic  busy,
    output logic  done,
    output logic  result,
    output logic  error,
    output cnt_t  visits
);
    walk_st_e st;
    cnt_t     cnt;
    cnt_t     cnt_inc;
    logic     limit_hit;

    always_comb begin
        cnt_inc   = cnt + 1'b1;
        limit_hit = (cnt_inc == SB_CNT_W'(SB_NODES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            vec_q  <= '0;
            cur    <= '0;
            cnt    <= '0;
            done   <= 1'b0;
            result <= 1'b0;
            error  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        vec_q  <= in_vec;
                        cur    <= '0;
                        cnt    <= '0;
                        result <= 1'b0;
                        error  <= 1'b0;
                        st     <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    cnt <= cnt_inc;
                    if (!has_next) begin
                        result <= lit;
                        done   <= 1'b1;
                        st     <= ST_IDLE;
                    end else if (limit_hit) begin
                        result <= 1'b0;
                        error  <= 1'b1;
                        done   <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        cur <= nxt[SB_ADDR_W-1:0];
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st == ST_WALK);
    assign visits = cnt;
endmodule

// File: rtl/ssbdd_eval.sv
module ssbdd_eval
    import ssbdd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SB_ADDR_W-1:0] wr_addr,
    input  logic [SB_VIDX_W-1:0] wr_var,
    input  logic                 wr_cmpl,
    input  logic [SB_PTR_W-1:0]  wr_right,
    input  logic [SB_PTR_W-1:0]  wr_down,
    input  logic                 start,
    input  logic [SB_NVARS-1:0]  in_vec,
    output logic                 busy,
    output logic                 done,
    output logic                 result,
    output logic                 error,
    output logic [SB_CNT_W-1:0]  visits
);
    node_t wnode, rnode;
    addr_t cur;
    vec_t  vec_q;
    logic  lit, has_next;
    ptr_t  nxt;

    always_comb begin
        wnode.var_idx = wr_var;
        wnode.cmpl    = wr_cmpl;
        wnode.right   = wr_right;
        wnode.down    = wr_down;
    end

    ssbdd_node_table u_tab (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && !busy),
        .waddr (wr_addr),
        .wdata (wnode),
        .raddr (cur),
        .rdata (rnode)
    );

    ssbdd_lit_sel u_sel (
        .vec      (vec_q),
        .node     (rnode),
        .lit      (lit),
        .nxt      (nxt),
        .has_next (has_next)
    );

    ssbdd_walker u_walk (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_vec   (in_vec),
        .lit      (lit),
        .nxt      (nxt),
        .has_next (has_next),
        .vec_q    (vec_q),
        .cur      (cur),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .error    (error),
        .visits   (visits)
    );
endmodule

// File: rtl/ssbdd_eval_chk.sv
module ssbdd_eval_chk
    import ssbdd_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 result,
    input logic                 error,
    input logic [SB_CNT_W-1:0]  visits
);
    // R5: completion strobe lasts one cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: outputs hold while idle and no start is presented
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(result) && $stable(error) && $stable(visits)));

    // R2: accepted start enters the walk with cleared status
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && visits == '0 && !error));

    // R2: done only on return to idle
    a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4: a finished walk visited between one and table-depth nodes
    a_r4_visit_range: assert property (@(posedge clk) disable iff (rst)
        done |-> (visits >= SB_CNT_W'(1) && visits <= SB_CNT_W'(SB_NODES)));

    // R8: guard stop reports full depth and a zero result
    a_r8_guard: assert property (@(posedge clk) disable iff (rst)
        (done && error) |-> (visits == SB_CNT_W'(SB_NODES) && !result));
endmodule

bind ssbdd_eval ssbdd_eval_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .error  (error),
    .visits (visits)
);

// File: tb/ssbdd_eval_tb.sv
module ssbdd_eval_tb;
    import ssbdd_pkg::*;

    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [2:0] wr_var = '0;
    logic       wr_cmpl = 1'b0;
    logic [4:0] wr_right = '0, wr_down = '0;
    logic       start = 1'b0;
    logic [7:0] in_vec = '0;
    logic       busy, done, result, error;
    logic [4:0] visits;

    int checks = 0;
    int fails  = 0;

    int m_var [16];
    int m_cm  [16];
    int m_r   [16];
    int m_d   [16];

    always #(CLK_NS/2) clk = ~clk;

    ssbdd_eval u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_var(wr_var),
        .wr_cmpl(wr_cmpl), .wr_right(wr_right), .wr_down(wr_down), .start(start),
        .in_vec(in_vec), .busy(busy), .done(done), .result(result), .error(error),
        .visits(visits)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void ref_walk(input logic [7:0] v, output int res, output int vis,
                                     output int err);
        int cur = 0;
        res = 0; vis = 0; err = 0;
        for (int k = 0; k < 17; k++) begin
            int lit, nx;
            vis++;
            lit = int'(v[m_var[cur]]) ^ m_cm[cur];
            nx  = (lit != 0) ? m_r[cur] : m_d[cur];
            if (nx >= 16) begin res = lit; return; end
            if (vis == 16) begin err = 1; res = 0; return; end
            cur = nx;
        end
    endfunction

    task automatic wr_node(input int a, input int v, input int c, input int r, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_var = 3'(v); wr_cmpl = 1'(c);
        wr_right = 5'(r); wr_down = 5'(d);
        m_var[a] = v; m_cm[a] = c; m_r[a] = r; m_d[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // mode 0: plain, 1: write during walk, 2: start during walk
    task automatic run_walk(input logic [7:0] v, input int mode, input string tag);
        int er, ev, ee, lat;
        bit got;
        logic r0; logic [4:0] v0; logic e0;
        ref_walk(v, er, ev, ee);
        @(negedge clk);
        start = 1'b1; in_vec = v;
        @(negedge clk);
        start = 1'b0; in_vec = ~v;
        check(busy == 1'b1, {tag, " R2 busy after start"}, int'(busy), 1);
        check(visits == 5'd0 && error == 1'b0, {tag, " R2 status cleared"}, int'(visits), 0);
        lat = 0; got = 0;
        while (!got && lat < 40) begin
            @(negedge clk);
            lat++;
            if (lat == 3 && mode == 1) begin
                wr_en = 1'b1; wr_addr = 4'd15; wr_var = 3'(m_var[15]);
                wr_cmpl = ~1'(m_cm[15]); wr_right = 5'(m_r[15]); wr_down = 5'(m_d[15]);
            end
            if (lat == 3 && mode == 2) start = 1'b1;
            if (lat == 4) begin wr_en = 1'b0; start = 1'b0; end
            if (done) got = 1;
        end
        check(got && lat == ev, {tag, " R2 done latency"}, lat, ev);
        check(result == 1'(er), {tag, " result"}, int'(result), er);
        check(int'(visits) == ev, {tag, " visits"}, int'(visits), ev);
        check(error == 1'(ee), {tag, " R8 error flag"}, int'(error), ee);
        r0 = result; v0 = visits; e0 = error;
        @(negedge clk);
        check(done == 1'b0, {tag, " R5 done one cycle"}, int'(done), 0);
        check(result == r0 && visits == v0 && error == e0, {tag, " R5 outputs held"},
              int'(visits), int'(v0));
    endtask

    task automatic load_chain(input bit loop_back);
        for (int i = 0; i < 16; i++) begin
            if (i < 15) wr_node(i, i % 8, 0, i + 1, i + 1);
            else if (loop_back) wr_node(i, 7, 0, 0, 0);
            else wr_node(i, 7, 0, 31, 31);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd20240611);
        for (int i = 0; i < 16; i++) begin
            m_var[i] = 0; m_cm[i] = 0; m_r[i] = 31; m_d[i] = 31;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !result && !error && visits == 0, "R1 reset outputs",
              int'(visits), 0);
        run_walk(8'h01, 0, "R1 blank table bit0=1");
        run_walk(8'hFE, 0, "R1 blank table bit0=0");

        // R9: example function, vars a=0 b=1 c=2 d=3
        wr_node(0, 0, 0, 1, 2);    // a
        wr_node(1, 1, 0, 3, 2);    // b
        wr_node(2, 2, 1, 4, 31);   // not c (second branch)
        wr_node(3, 2, 0, 31, 2);   // c (first branch)
        wr_node(4, 3, 1, 31, 31);  // not d
        run_walk(8'b0000_0111, 0, "R9 abcd=1110");
        check(result == 1'b1 && visits == 5'd3, "R9 1110 gives 1 in 3", int'(visits), 3);
        run_walk(8'b0000_1001, 0, "R9 abcd=1001");
        check(result == 1'b0 && visits == 5'd4, "R9 1001 gives 0 in 4", int'(visits), 4);
        for (int n = 0; n < 16; n++) begin
            logic a, b, c, d, y;
            {d, c, b, a} = 4'(n);
            y = (a & b & c) | (~c & ~d);
            run_walk({4'h0, d, c, b, a}, 0, "R9 sweep");
            check(result == y, "R9 function value", int'(result), int'(y));
        end

        // R3 R4: random forward-only tables
        for (int t = 0; t < 6; t++) begin
            for (int i = 0; i < 16; i++) begin
                int r, d;
                r = (i < 15 && ($urandom % 4) != 0) ? i + 1 + int'($urandom % (15 - i)) : 31;
                d = (i < 15 && ($urandom % 4) != 0) ? i + 1 + int'($urandom % (15 - i)) : 31;
                if (($urandom % 8) == 0) r = 16 + int'($urandom % 15);
                wr_node(i, int'($urandom % 8), int'($urandom % 2), r, d);
            end
            for (int k = 0; k < 12; k++) run_walk(8'($urandom), 0, "R3 R4 random table");
        end

        // longest legal walk, then writes and starts during it
        load_chain(1'b0);
        run_walk(8'h80, 0, "R4 chain 16 visits");
        run_walk(8'h80, 1, "R6 write while busy");
        run_walk(8'h80, 0, "R6 table unchanged after");
        run_walk(8'h00, 2, "R7 start while busy");
        run_walk(8'h80, 2, "R7 start while busy hi");

        // R8: cyclic table
        load_chain(1'b1);
        run_walk(8'h5A, 0, "R8 loop guard");
        check(error == 1'b1 && visits == 5'd16, "R8 guard visits", int'(visits), 16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule